// File: doc/BRIEF.md
# Second-Order One-Bit Delta-Sigma Modulator

This block is a digital model of a second-order delta-sigma modulator. A signed 16-bit sample, standing for a differential input voltage, is turned into a one-bit stream whose long-run fraction of ones follows the input value. A decimating filter downstream recovers the value from that fraction. One decision is made on every rising edge of the master clock, and the same clock both paces the loop and frames the serial output. The input is sampled continuously. There is no conversion-start handshake and no sample-and-hold.

The loop holds two cascaded saturating integrators and a single-bit quantizer. The quantizer bit selects a feedback of +32768 or -32768, and that feedback is subtracted in both integrators. Codes -32768 and +32767 stand for the absolute full scale. Codes -20480 and +20480 stand for the specified span, which is 0.625 of full scale, so that span gives 18.75 % to 81.25 % ones. The expected ones-density for a held input x is (x + 32768) / 65536.

The loop is a single always-running datapath with no mode sequencing. It has two states in practice: cleared (reset held) and modulating (reset released).

Top module: `dsm2_modulator`

## Requirements
- R1: While `rst` is high at a rising edge, both integrators clear and `bit_out` is 0 after that edge.
- R2: With `sample_in` held at 0, the fraction of ones over 4096 clocks after settling is 50 % within ±0.5 % (2048 ± 20 ones).
- R3: With `sample_in` held at +20480, the fraction of ones is 81.25 % within ±0.5 % (3328 ± 20 of 4096).
- R4: With `sample_in` held at -20480, the fraction of ones is 18.75 % within ±0.5 % (768 ± 20 of 4096).
- R5: With `sample_in` held at +32767, the stream is all ones within 0.5 % (at least 4076 of 4096).
- R6: With `sample_in` held at -32768 or -32767, the stream is all zeros within 0.5 % (at most 20 of 4096).
- R7: For any held input x in [-20480, +20480], the count of ones over 4096 clocks is (x + 32768) / 16 within ±20.
- R8: On each clock, the first integrator adds `sample_in` and subtracts +32768 when the current `bit_out` is 1, or -32768 when it is 0.
- R9: `bit_out` is a register updated on the rising edge. After each edge it equals 1 exactly when the second integrator is greater than or equal to zero.
- R10: Both integrators saturate at the limits of their signed width and never wrap from one sign to the other.
- R11: The first bit after reset is released is 1 for every input value, because the cleared feedback state subtracts -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one modulator decision per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 16 | Signed two's-complement input sample, read every clock |
| bit_out | output | 1 | Serial one-bit stream, launched on a rising edge and valid at the next |

## Verification
The assertions check four things on every cycle. They check that reset clears the integrators and the output, and that the output bit always agrees with the sign of the second integrator. They check that the first integrator moves by exactly the input minus the feedback chosen by the current bit. They also check that neither integrator ever flips sign through a wrap. The ones-density for each held input can only be shown by the bench's scenarios, which count bits over long windows. These include the full-scale saturation into all ones or all zeros and the first bit after reset release.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

    // number of cascaded integrators in the loop
    localparam int NUM_STAGES = 2;

    // feedback polarity selected by the quantizer bit
    typedef enum logic {
        FB_NEG = 1'b0,
        FB_POS = 1'b1
    } fb_pol_e;

endpackage

// File: rtl/dsm2_integrator.sv
module dsm2_integrator #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ACC_W-1:0] inc,
    input  dsm2_pkg::fb_pol_e       fb_pol,
    output logic signed [ACC_W-1:0] acc_next,
    output logic signed [ACC_W-1:0] acc_q
);

    localparam int EXT_W = ACC_W + 2;
    localparam logic signed [EXT_W-1:0] FB_MAG = EXT_W'(64'sd1 <<< (IN_W - 1));
    localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] SAT_LO = -SAT_HI - EXT_W'(1);

    logic signed [EXT_W-1:0] fb_term;
    logic signed [EXT_W-1:0] raw_sum;

    always_comb begin
        fb_term = (fb_pol == dsm2_pkg::FB_POS) ? FB_MAG : -FB_MAG;
        raw_sum = EXT_W'(acc_q) + EXT_W'(inc) - fb_term;
        if (raw_sum > SAT_HI) begin
            acc_next = SAT_HI[ACC_W-1:0];
        end else if (raw_sum < SAT_LO) begin
            acc_next = SAT_LO[ACC_W-1:0];
        end else begin
            acc_next = raw_sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/dsm2_quantizer.sv
module dsm2_quantizer #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ACC_W-1:0] level_next,
    output logic                    bit_q
);

    // decide on the value the last integrator is about to hold
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= ~level_next[ACC_W-1];
        end
    end

endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] sample_in,
    output logic                   bit_out
);

    localparam int NST = dsm2_pkg::NUM_STAGES;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] stage_in [NST];
    logic signed [ACC_W-1:0] stage_d  [NST];
    logic signed [ACC_W-1:0] stage_q  [NST];
    logic signed [ACC_W-1:0] integ1_q;
    logic signed [ACC_W-1:0] integ2_q;
    dsm2_pkg::fb_pol_e       fb_pol;
    logic                    bit_q;

    assign x_ext  = ACC_W'(sample_in);
    assign fb_pol = bit_q ? dsm2_pkg::FB_POS : dsm2_pkg::FB_NEG;

    for (genvar k = 0; k < NST; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign stage_in[k] = x_ext;
        end else begin : g_next
            assign stage_in[k] = stage_d[k-1];
        end
        dsm2_integrator #(
            .IN_W  (IN_W),
            .ACC_W (ACC_W)
        ) u_integ (
            .clk      (clk),
            .rst      (rst),
            .inc      (stage_in[k]),
            .fb_pol   (fb_pol),
            .acc_next (stage_d[k]),
            .acc_q    (stage_q[k])
        );
    end

    dsm2_quantizer #(
        .ACC_W (ACC_W)
    ) u_quant (
        .clk        (clk),
        .rst        (rst),
        .level_next (stage_d[NST-1]),
        .bit_q      (bit_q)
    );

    assign integ1_q = stage_q[0];
    assign integ2_q = stage_q[NST-1];
    assign bit_out  = bit_q;

endmodule

// File: rtl/dsm2_modulator_chk.sv
module dsm2_modulator_chk #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic signed [IN_W-1:0]  din,
    input logic                    dout,
    input logic signed [ACC_W-1:0] a1,
    input logic signed [ACC_W-1:0] a2
);

    localparam int EW = ACC_W + 2;
    localparam logic signed [EW-1:0]    FS  = EW'(64'sd1 <<< (IN_W - 1));
    localparam logic signed [ACC_W-1:0] BIG = ACC_W'(64'sd1 <<< (ACC_W - 2));

    logic                    armed;
    logic signed [ACC_W-1:0] p_a1;
    logic signed [IN_W-1:0]  p_din;
    logic                    p_dout;
    logic signed [EW-1:0]    a1_pred;
    logic                    p_small;

    always_ff @(posedge clk) begin
        armed  <= !rst;
        p_a1   <= a1;
        p_din  <= din;
        p_dout <= dout;
    end

    always_comb begin
        a1_pred = EW'(p_a1) + EW'(p_din) - (p_dout ? FS : -FS);
        p_small = (p_a1 < BIG) && (p_a1 > -BIG);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == 1'b0 && a1 == '0 && a2 == '0));

    // R9
    quant_sign_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (dout == (a2 >= 0)));

    // R8
    feedback_step_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && p_small) |-> (a1 == a1_pred[ACC_W-1:0]));

    // R10
    no_wrap_a1_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && (p_a1 >= BIG || p_a1 <= -BIG)) |-> (a1[ACC_W-1] == p_a1[ACC_W-1]));

    // R10
    no_wrap_a2_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(a2) >= BIG || $past(a2) <= -BIG)) |-> (a2[ACC_W-1] == $past(a2[ACC_W-1])));

endmodule

bind dsm2_modulator dsm2_modulator_chk #(
    .IN_W  (IN_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .din  (sample_in),
    .dout (bit_out),
    .a1   (integ1_q),
    .a2   (integ2_q)
);

// File: tb/dsm2_modulator_bench.sv
module dsm2_modulator_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 4096;
    localparam int SETTLE     = 512;
    localparam int TOL        = 20;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] sample_in = '0;
    logic               bit_out;

    int checks = 0;
    int fails  = 0;

    dsm2_modulator u_dsm2_modulator (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .bit_out   (bit_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_ones(input int x);
        return ((x + 32768) * WINDOW) / 65536;
    endfunction

    task automatic check(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic run_case(input int x, input string req);
        int ones;
        int e;
        @(negedge clk);
        rst       = 1'b1;
        sample_in = 16'(x);
        repeat (2) @(negedge clk);
        check("R1", int'(bit_out), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        // R11: first bit after release
        check("R11", int'(bit_out), 1, 1);
        repeat (SETTLE) @(negedge clk);
        ones = 0;
        for (int i = 0; i < WINDOW; i++) begin
            @(negedge clk);
            if (bit_out) ones++;
        end
        e = exp_ones(x);
        check(req, ones, e - TOL, e + TOL);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: output held low during reset from time zero
        check("R1", int'(bit_out), 0, 0);
        run_case(0, "R2");
        run_case(20480, "R3");
        run_case(-20480, "R4");
        run_case(32767, "R5");
        run_case(-32768, "R6");
        run_case(-32767, "R6");
        // R7: edges of the specified span and random held inputs
        run_case(20479, "R7");
        run_case(-1, "R7");
        for (int n = 0; n < 8; n++) begin
            run_case(int'($urandom_range(40960)) - 20480, "R7");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule